// File: doc/BRIEF.md
# USB Receive DMA Transaction Counter

This block keeps count of completed OUT transactions on each receive DMA channel of a USB device controller. Software writes a per-channel control word that holds a transaction count and a stop flag. After software enables the channel, each transaction-complete pulse from the packet engine moves a remaining-transactions counter down by one. When the programmed watermark is reached, a sticky count flag is set.

The stop flag decides what happens at the watermark. With the flag clear, the counter reloads and the transfer keeps running, so the count flag comes back every N+1 transactions. With the flag set, the block also sets a sticky end-of-transfer flag, drops the channel out of the active state and asserts a NAK request. The packet engine uses that request to refuse further OUT tokens until software enables the channel again. Three channels sit side by side and share one small register port. The channel control words are at addresses 0 to 2 and a shared flag word is at address 3.

Top module: `out_txn_watch`

## Requirements
- R1: A channel control word (address 0, 1 or 2 for channels 0, 1, 2) has the stop flag in bit 15 and the count field in bits 7:0. Bits 14:8 ignore writes and read as zero.
- R2: With the count field programmed to N, the count flag of channel i is set on the (N+1)-th accepted transaction-complete pulse after the channel is enabled. This flag is bit i of the flag word at address 3.
- R3: With the stop flag clear, the channel stays active after the watermark and the counter reloads, so the count flag is raised again after every further N+1 accepted pulses.
- R4: With the stop flag set, the watermark sets both the count flag and the end-of-transfer flag (bit 4+i of the flag word), clears chanActive[i] and raises nakOut[i] in the same cycle.
- R5: nakOut[i] stays high until a fifoEnSet[i] pulse. That pulse makes the channel active, lowers nakOut[i] and reloads the counter from the count field.
- R6: A read of a control word returns the number of transactions left before the next count flag, minus one, in bits 7:0. This equals the written value just after a write or enable, and it drops by one on each accepted pulse.
- R7: A transaction-complete pulse on a channel that is not active changes neither its counter nor its flags.
- R8: The flags are sticky. Writing a one to a flag bit at address 3 clears that bit, and writing a zero has no effect. The irq output is the OR of all flags.
- R9: System reset (rstN low) and a usbReset pulse both clear the stop flag, the count field, the counter, all flags, the active state and the NAK request.
- R10: Each channel counts only its own pulses, so activity on one channel leaves another channel's counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | System reset, active low |
| usbReset | input | 1 | USB bus reset pulse, clears all channel state |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0..2 channel control, 3 flags |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr (combinational) |
| txnDone | input | 3 | Per-channel OUT transaction-complete pulse |
| fifoEnSet | input | 3 | Per-channel enable pulse from software |
| chanActive | output | 3 | Channel is counting |
| nakOut | output | 3 | Channel requests NAK on OUT tokens |
| cntIrq | output | 3 | Sticky count flags |
| eotIrq | output | 3 | Sticky end-of-transfer flags |
| irq | output | 1 | OR of all flags |

## Verification
The main function is driven from a table of runs. Each run varies the channel, the count value (0, small values and 255), the stop flag and the number of pulses. These runs separate stopping short of the watermark, landing exactly on it, running past it with a reload, and running past it after a stop, where the extra pulses must be ignored. Directed tests cover the reserved bits, pulses on an idle or halted channel, re-enabling after a NAK, single-bit flag clears, cross-channel isolation and the bus reset.

// File: rtl/otw_pkg.sv
package otw_pkg;
  // Per-cycle commands from channel control to channel datapath
  typedef struct packed {
    logic reload;  // load counter from the count field
    logic dec;     // step counter down by one
    logic hit;     // watermark reached on this cycle
  } stepCmd_t;
endpackage

// File: rtl/otw_datapath.sv
module otw_datapath
  import otw_pkg::*;
#(
  parameter int TCW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           usbReset,
  input  logic           wrCfg,
  input  logic           wrStop,
  input  logic [TCW-1:0] wrTc,
  input  stepCmd_t       cmd,
  output logic           stopBit,
  output logic [TCW-1:0] remM1,
  output logic           atZero
);
  logic [TCW-1:0] tcVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBit <= 1'b0;
      tcVal   <= '0;
      remM1   <= '0;
    end else if (usbReset) begin
      stopBit <= 1'b0;
      tcVal   <= '0;
      remM1   <= '0;
    end else if (wrCfg) begin
      stopBit <= wrStop;
      tcVal   <= wrTc;
      remM1   <= wrTc;
    end else if (cmd.reload) begin
      remM1 <= tcVal;
    end else if (cmd.dec) begin
      remM1 <= remM1 - TCW'(1);
    end
  end

  assign atZero = (remM1 == '0);
endmodule

// File: rtl/otw_ctrl.sv
module otw_ctrl
  import otw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     usbReset,
  input  logic     wrCfg,
  input  logic     txnDone,
  input  logic     fifoEnSet,
  input  logic     atZero,
  input  logic     stopBit,
  input  logic     clrCnt,
  input  logic     clrEot,
  output stepCmd_t cmd,
  output logic     active,
  output logic     nak,
  output logic     cntFlag,
  output logic     eotFlag
);
  logic take;
  logic stopNow;

  // A pulse counts only on an active channel with no config write or re-enable
  assign take    = active && txnDone && !wrCfg && !fifoEnSet && !usbReset;
  assign cmd.hit = take && atZero;
  assign cmd.dec = take && !atZero;
  assign cmd.reload = cmd.hit || (fifoEnSet && !wrCfg);
  assign stopNow = cmd.hit && stopBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      nak     <= 1'b0;
      cntFlag <= 1'b0;
      eotFlag <= 1'b0;
    end else if (usbReset) begin
      active  <= 1'b0;
      nak     <= 1'b0;
      cntFlag <= 1'b0;
      eotFlag <= 1'b0;
    end else begin
      if (fifoEnSet) begin
        active <= 1'b1;
        nak    <= 1'b0;
      end else if (stopNow) begin
        active <= 1'b0;
        nak    <= 1'b1;
      end
      if (cmd.hit)     cntFlag <= 1'b1;
      else if (clrCnt) cntFlag <= 1'b0;
      if (stopNow)     eotFlag <= 1'b1;
      else if (clrEot) eotFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/out_txn_watch.sv
module out_txn_watch
  import otw_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int TCW      = 8,
  parameter int DW       = 16,
  parameter int STOP_POS = 15,
  parameter int EOT_BASE = 4,
  parameter int AW       = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           usbReset,
  input  logic           regWe,
  input  logic [AW-1:0]  regAddr,
  input  logic [DW-1:0]  regWdata,
  output logic [DW-1:0]  regRdata,
  input  logic [NCH-1:0] txnDone,
  input  logic [NCH-1:0] fifoEnSet,
  output logic [NCH-1:0] chanActive,
  output logic [NCH-1:0] nakOut,
  output logic [NCH-1:0] cntIrq,
  output logic [NCH-1:0] eotIrq,
  output logic           irq
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(NCH);

  logic [NCH-1:0] stopV;
  logic [TCW-1:0] remV [NCH];
  logic           flagWr;

  assign flagWr = regWe && (regAddr == FLAG_ADDR);

  for (genvar g = 0; g < NCH; g++) begin : gCh
    logic     wrCfg;
    logic     atZero;
    stepCmd_t cmd;

    assign wrCfg = regWe && (regAddr == AW'(g));

    otw_datapath #(.TCW(TCW)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .usbReset(usbReset),
      .wrCfg   (wrCfg),
      .wrStop  (regWdata[STOP_POS]),
      .wrTc    (regWdata[TCW-1:0]),
      .cmd     (cmd),
      .stopBit (stopV[g]),
      .remM1   (remV[g]),
      .atZero  (atZero)
    );

    otw_ctrl u_ctl (
      .clk      (clk),
      .rstN     (rstN),
      .usbReset (usbReset),
      .wrCfg    (wrCfg),
      .txnDone  (txnDone[g]),
      .fifoEnSet(fifoEnSet[g]),
      .atZero   (atZero),
      .stopBit  (stopV[g]),
      .clrCnt   (flagWr && regWdata[g]),
      .clrEot   (flagWr && regWdata[EOT_BASE+g]),
      .cmd      (cmd),
      .active   (chanActive[g]),
      .nak      (nakOut[g]),
      .cntFlag  (cntIrq[g]),
      .eotFlag  (eotIrq[g])
    );
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == FLAG_ADDR) begin
      regRdata[NCH-1:0]          = cntIrq;
      regRdata[EOT_BASE+:NCH]    = eotIrq;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (regAddr == AW'(i)) begin
          regRdata[STOP_POS]  = stopV[i];
          regRdata[TCW-1:0]   = remV[i];
        end
      end
    end
  end

  assign irq = |{cntIrq, eotIrq};
endmodule

// File: rtl/otw_checker.sv
module otw_checker #(
  parameter int NCH      = 3,
  parameter int TCW      = 8,
  parameter int DW       = 16,
  parameter int STOP_POS = 15,
  parameter int AW       = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           usbReset,
  input logic           regWe,
  input logic [AW-1:0]  regAddr,
  input logic [DW-1:0]  regRdata,
  input logic [NCH-1:0] txnDone,
  input logic [NCH-1:0] fifoEnSet,
  input logic [NCH-1:0] chanActive,
  input logic [NCH-1:0] nakOut,
  input logic [NCH-1:0] cntIrq,
  input logic [NCH-1:0] eotIrq
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < AW'(NCH)) |-> (regRdata[STOP_POS-1:TCW] == '0)); // R1

  AST_USBRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    usbReset |=> (cntIrq == '0 && eotIrq == '0 && chanActive == '0 && nakOut == '0)); // R9

  for (genvar k = 0; k < NCH; k++) begin : gChk
    AST_EOT_WITH_CNT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(eotIrq[k]) |-> cntIrq[k]); // R4

    AST_EOT_HALTS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(eotIrq[k]) |-> (!chanActive[k] && nakOut[k])); // R4

    AST_NAK_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
      nakOut[k] |-> !chanActive[k]); // R5

    AST_NAK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (nakOut[k] && !fifoEnSet[k] && !usbReset) |=> nakOut[k]); // R5

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
      (!chanActive[k] && txnDone[k] && !fifoEnSet[k] && !regWe && !usbReset)
        |=> $stable(cntIrq[k])); // R7
  end
endmodule

bind out_txn_watch otw_checker #(
  .NCH(NCH), .TCW(TCW), .DW(DW), .STOP_POS(STOP_POS), .AW(AW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .usbReset  (usbReset),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regRdata  (regRdata),
  .txnDone   (txnDone),
  .fifoEnSet (fifoEnSet),
  .chanActive(chanActive),
  .nakOut    (nakOut),
  .cntIrq    (cntIrq),
  .eotIrq    (eotIrq)
);

// File: tb/out_txn_watch_bench.sv
`timescale 1ns/1ps
module out_txn_watch_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usbReset = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [2:0]  txnDone = '0;
  logic [2:0]  fifoEnSet = '0;
  logic [2:0]  chanActive, nakOut, cntIrq, eotIrq;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  out_txn_watch u_out_txn_watch (
    .clk(clk), .rstN(rstN), .usbReset(usbReset), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txnDone(txnDone), .fifoEnSet(fifoEnSet), .chanActive(chanActive),
    .nakOut(nakOut), .cntIrq(cntIrq), .eotIrq(eotIrq), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] ch;
    logic [7:0] tc;
    logic       stop;
    logic [7:0] n;
    logic [7:0] rem;
    logic       cnt;
    logic       eot;
    logic       act;
  } vec_t;

  // Expected results worked out from R2, R3, R4, R6, R7
  localparam vec_t VEC [8] = '{
    '{2'd0, 8'd3,   1'b0, 8'd2,  8'd1,   1'b0, 1'b0, 1'b1},
    '{2'd0, 8'd3,   1'b0, 8'd4,  8'd3,   1'b1, 1'b0, 1'b1},
    '{2'd1, 8'd0,   1'b0, 8'd3,  8'd0,   1'b1, 1'b0, 1'b1},
    '{2'd1, 8'd2,   1'b1, 8'd3,  8'd2,   1'b1, 1'b1, 1'b0},
    '{2'd2, 8'd2,   1'b1, 8'd5,  8'd2,   1'b1, 1'b1, 1'b0},
    '{2'd2, 8'd5,   1'b0, 8'd9,  8'd2,   1'b1, 1'b0, 1'b1},
    '{2'd0, 8'd0,   1'b1, 8'd1,  8'd0,   1'b1, 1'b1, 1'b0},
    '{2'd1, 8'd255, 1'b0, 8'd10, 8'd245, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulses(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); txnDone[ch] = 1'b1;
      @(negedge clk); txnDone[ch] = 1'b0;
    end
  endtask

  task automatic enable(input int ch);
    @(negedge clk); fifoEnSet[ch] = 1'b1;
    @(negedge clk); fifoEnSet[ch] = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    testsFailed++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(a[1:0], d);
      check("R9 reset readback", d, 0);
    end
    check("R9 reset outputs", {chanActive, nakOut, cntIrq, eotIrq, irq}, 0);

    // R7: pulses on a never-enabled channel
    wrReg(2'd0, 16'h0002);
    pulses(0, 3);
    rdReg(2'd0, d);
    check("R7 idle counter", d, 16'h0002);
    check("R7 idle flags", cntIrq[0], 0);

    // R1: reserved bits read as zero
    wrReg(2'd2, 16'hFFFF);
    rdReg(2'd2, d);
    check("R1 control word", d, 16'h80FF);

    // Table runs
    for (int v = 0; v < 8; v++) begin
      wrReg(VEC[v].ch, {VEC[v].stop, 7'd0, VEC[v].tc});
      enable(VEC[v].ch);
      wrReg(2'd3, 16'h0077);
      pulses(VEC[v].ch, VEC[v].n);
      rdReg(VEC[v].ch, d);
      check("R6 remaining", d[7:0], VEC[v].rem);
      check("R2 count flag", cntIrq[VEC[v].ch], VEC[v].cnt);
      check("R4 eot flag", eotIrq[VEC[v].ch], VEC[v].eot);
      check("R3 active", chanActive[VEC[v].ch], VEC[v].act);
      check("R4 nak", nakOut[VEC[v].ch], !VEC[v].act);
    end

    // R5: halted channel 0 (count 0, stop set) ignores pulses, then re-enables
    wrReg(2'd3, 16'h0077);
    check("R5 nak held", nakOut[0], 1);
    pulses(0, 2);
    check("R5 halted no count", cntIrq[0], 0);
    enable(0);
    check("R5 nak released", nakOut[0], 0);
    check("R5 active again", chanActive[0], 1);
    pulses(0, 1);
    check("R5 count after enable", cntIrq[0], 1);
    check("R5 eot after enable", eotIrq[0], 1);

    // R8: sticky flags and one-bit clears
    repeat (5) @(negedge clk);
    wrReg(2'd3, 16'h0000);
    rdReg(2'd3, d);
    check("R8 write zero keeps", d, 16'h0011);
    wrReg(2'd3, 16'h0010);
    rdReg(2'd3, d);
    check("R8 clear eot only", d, 16'h0001);
    check("R8 irq on", irq, 1);
    wrReg(2'd3, 16'h0001);
    check("R8 irq off", irq, 0);

    // R10: channel 2 activity leaves channel 1 alone
    pulses(2, 2);
    rdReg(2'd1, d);
    check("R10 ch1 untouched", d[7:0], 245);
    rdReg(2'd2, d);
    check("R10 ch2 counted", d[7:0], 0);

    // R9: bus reset
    pulses(1, 1);
    @(negedge clk); usbReset = 1'b1;
    @(negedge clk); usbReset = 1'b0;
    rdReg(2'd1, d);
    check("R9 usb reset ch1", d, 0);
    rdReg(2'd2, d);
    check("R9 usb reset ch2", d, 0);
    rdReg(2'd3, d);
    check("R9 usb reset flags", d, 0);
    check("R9 usb reset state", {chanActive, nakOut}, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule